// File: doc/BRIEF.md
# Compare-Match PWM Channel with Data-Request Strobe

This block is one edge-aligned PWM channel running on a free-running up-counter. The counter starts from a programmable start value, climbs to a programmable top value and then reloads. The channel output is high from the start of each period until the counter reaches the compare value, and low for the rest of the period. A compare match can raise a data-request strobe. An external data mover answers that strobe by writing the next compare value and pulsing acknowledge. A sine table streamed this way yields sine-weighted PWM with no processor work per period.

Configuration comes through a small register-write port. The compare value arrives through its own write port, which the mover drives. While the counter runs, a new compare value is staged and takes effect at the next reload, so each period uses a single value. A debug-halt input either freezes the channel or is ignored, according to a run-while-halted bit.

Top module: `pwm_req_chan`

## Requirements
- R1: Config address 1 holds the start value and address 2 the top value (reset 0xFFFF). While running, the counter goes from the start value up to the top value and then reloads to the start value, so the period is top-start+1 cycles. A count at or above the top value also reloads.
- R2: `pwm_o` is high while the count is below the active compare value and low otherwise, so with start 0 the high time is the compare value in cycles. While the clock-select field is zero, `pwm_o` is low.
- R3: While the counter runs, a compare write is staged and becomes active at the next reload. While the clock-select field is zero, a compare write becomes active at once.
- R4: A match raises `req_o` only when both bit 0 (interrupt enable) and bit 1 (request enable) of config address 3 are set. Either bit alone gives no request.
- R5: An active compare value of 0 gives 0% duty and never produces a match: no flag and no request.
- R6: `req_o` stays high until `ack_i` is pulsed. Further matches before the acknowledge merge into the one pending request. If a match and an acknowledge fall in the same cycle, the match wins.
- R7: `flag_o` is set on every match, whatever the enable bits, and is cleared by `ack_i`.
- R8: Config address 0 bit 2 is the run-while-halted bit. With it clear, `dbg_halt_i` freezes the counter and suppresses matches, and `pwm_o` holds its level. With it set, the channel and its requests run on through the halt.
- R9: Config address 0 bits 1:0 are the clock-select field. When it is zero the counter stops, and any nonzero value runs the counter at the input clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 16 | Configuration write data |
| cmp_we_i | input | 1 | Compare value write strobe from the mover |
| cmp_wdata_i | input | 16 | Compare value from the mover |
| ack_i | input | 1 | Request acknowledge pulse |
| dbg_halt_i | input | 1 | Debug halt |
| pwm_o | output | 1 | High-true PWM output |
| req_o | output | 1 | Data-request strobe |
| flag_o | output | 1 | Channel match flag |

## Verification
A counter that reloads at the wrong point shows up as a wrong number of rising edges within a fixed window of samples. A wrong compare value shows up as a wrong count of high samples in that window, visible within one period. Staging that is broken or bypassed shows at the first falling edge after a mid-period write: the output goes high again in that same period instead of staying low until the reload. A stuck or mis-gated request shows within about one period, as a request that appears without both enables, fails to clear on acknowledge, or clears before it. With a zero compare value, the request stays quiet for as long as that value is active.

// File: rtl/pwm_req_pkg.sv
package pwm_req_pkg;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_INIT = 2'd1,
    ADDR_MOD  = 2'd2,
    ADDR_CHAN = 2'd3
  } cfg_addr_e;

  typedef struct packed {
    logic       dbg_run;
    logic [1:0] clk_sel;
  } tb_ctrl_t;

  typedef struct packed {
    logic req_en;
    logic irq_en;
  } chan_ctrl_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_req_pkg::*;
#(
  parameter int unsigned CNT_W = pwm_req_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output tb_ctrl_t         ctrl_o,
  output chan_ctrl_t       chan_o,
  output logic [CNT_W-1:0] init_o,
  output logic [CNT_W-1:0] mod_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      chan_o <= '0;
      init_o <= '0;
      mod_o  <= '1;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        ADDR_CTRL: ctrl_o <= tb_ctrl_t'(wdata_i[2:0]);
        ADDR_INIT: init_o <= wdata_i;
        ADDR_MOD:  mod_o  <= wdata_i;
        ADDR_CHAN: chan_o <= chan_ctrl_t'(wdata_i[1:0]);
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_req_pkg::*;
#(
  parameter int unsigned CNT_W = pwm_req_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tb_ctrl_t         ctrl_i,
  input  logic             dbg_halt_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic [CNT_W-1:0] mod_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             enabled_o,
  output logic             run_o,
  output logic             reload_o
);
  assign enabled_o = |ctrl_i.clk_sel;
  assign run_o     = enabled_o && (!dbg_halt_i || ctrl_i.dbg_run);
  assign reload_o  = run_o && (cnt_o >= mod_i);  // >= recovers from a lowered top value

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_o <= '0;
    else if (reload_o) cnt_o <= init_i;
    else if (run_o)    cnt_o <= cnt_o + 1'b1;
  end

  a_r1_reload_to_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> cnt_o == $past(init_i));
  a_r8_frozen_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |=> $stable(cnt_o));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned CNT_W = pwm_req_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             enabled_i,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic             pwm_o,
  output logic             match_o
);
  logic [CNT_W-1:0] staged_q, active_q;
  logic             load_now;

  assign load_now = cmp_we_i && !enabled_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= '0;
      active_q <= '0;
    end else begin
      if (cmp_we_i) staged_q <= cmp_wdata_i;
      if (load_now)      active_q <= cmp_wdata_i;
      else if (reload_i) active_q <= cmp_we_i ? cmp_wdata_i : staged_q;
    end
  end

  assign match_o = run_i && (cnt_i == active_q) && (active_q != '0);
  assign pwm_o   = enabled_i && (cnt_i < active_q);

  a_r3_hold_between_reloads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && !load_now) |=> $stable(active_q));
  a_r3_reload_takes_staged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !cmp_we_i && !load_now) |=> active_q == $past(staged_q));
endmodule

// File: rtl/pwm_req_ctrl.sv
module pwm_req_ctrl
  import pwm_req_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_i,
  input  chan_ctrl_t chan_i,
  input  logic       ack_i,
  output logic       req_o,
  output logic       flag_o
);
  logic req_gate;
  assign req_gate = chan_i.irq_en && chan_i.req_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (match_i)    flag_o <= 1'b1;
      else if (ack_i) flag_o <= 1'b0;
      if (match_i && req_gate) req_o <= 1'b1;
      else if (ack_i)          req_o <= 1'b0;
    end
  end

  a_r4_no_req_without_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_gate && !req_o) |=> !req_o);
  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !match_i) |=> (!flag_o && !req_o));
  a_r7_match_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_o);
endmodule

// File: rtl/pwm_req_chan.sv
module pwm_req_chan
  import pwm_req_pkg::*;
#(
  parameter int unsigned CNT_W = pwm_req_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             ack_i,
  input  logic             dbg_halt_i,
  output logic             pwm_o,
  output logic             req_o,
  output logic             flag_o
);
  tb_ctrl_t         ctrl;
  chan_ctrl_t       chan;
  logic [CNT_W-1:0] init_val, mod_val, cnt;
  logic             enabled, run, reload, match;

  pwm_cfg_regs #(.CNT_W(CNT_W)) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ctrl_o(ctrl), .chan_o(chan), .init_o(init_val), .mod_o(mod_val)
  );

  pwm_timebase #(.CNT_W(CNT_W)) i_tb (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .dbg_halt_i, .init_i(init_val), .mod_i(mod_val),
    .cnt_o(cnt), .enabled_o(enabled), .run_o(run), .reload_o(reload)
  );

  pwm_compare #(.CNT_W(CNT_W)) i_cmp (
    .clk_i, .rst_ni, .cnt_i(cnt), .enabled_i(enabled), .run_i(run), .reload_i(reload),
    .cmp_we_i, .cmp_wdata_i, .pwm_o, .match_o(match)
  );

  pwm_req_ctrl i_req (
    .clk_i, .rst_ni, .match_i(match), .chan_i(chan), .ack_i, .req_o, .flag_o
  );

  a_r9_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.clk_sel == 2'b00) |-> !pwm_o);
endmodule

// File: tb/test_pwm_req_chan.sv
module test_pwm_req_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        cmp_we = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        ack = 1'b0;
  logic        halt = 1'b0;
  logic        pwm, req, flag;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwm_req_chan i_pwm_req_chan (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wdata),
    .ack_i(ack), .dbg_halt_i(halt), .pwm_o(pwm), .req_o(req), .flag_o(flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic mover_write(input logic [15:0] d);
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = d;
    @(negedge clk); cmp_we = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n samples for highs, n intervals for rising edges
  task automatic measure(input int n, output int highs, output int rises);
    logic prev;
    @(negedge clk);
    prev = pwm; highs = int'(pwm); rises = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i < n && pwm) highs++;
      if (pwm && !prev) rises++;
      prev = pwm;
    end
  endtask

  task automatic t_reset();
    check(pwm == 1'b0, "R2 reset pwm", pwm, 0);
    check(req == 1'b0, "R6 reset req", req, 0);
    check(flag == 1'b0, "R7 reset flag", flag, 0);
  endtask

  task automatic t_period();
    int h, r;
    cfg_write(2'd1, 16'd0);
    cfg_write(2'd2, 16'd9);
    mover_write(16'd4);
    cfg_write(2'd3, 16'd3);
    wait_cycles(3);
    check(pwm == 1'b0, "R9 stopped pwm low", pwm, 0);
    check(flag == 1'b0, "R9 stopped no match", flag, 0);
    cfg_write(2'd0, 16'd1);
    wait_cycles(2);
    measure(30, h, r);
    check(h == 12, "R2 R3 high samples per 3 periods", h, 12);
    check(r == 3, "R1 rising edges in 30 cycles", r, 3);
  endtask

  task automatic t_req_merge();
    int seen;
    ack_pulse();
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (req) seen = 1;
    end
    check(seen == 1, "R6 request raised on match", seen, 1);
    check(flag == 1'b1, "R7 flag set with request", flag, 1);
    ack_pulse();
    check(req == 1'b0, "R6 ack clears request", req, 0);
    check(flag == 1'b0, "R7 ack clears flag", flag, 0);
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (req) seen = 1;
    end
    check(seen == 1, "R6 request raised again", seen, 1);
    // hold through further matches (every 10 cycles)
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      check(req == 1'b1, "R6 request held without ack", req, 1);
    end
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check(req == 1'b0, "R6 single ack clears merged request", req, 0);
    wait_cycles(3);
    check(req == 1'b0, "R6 no second pending request", req, 0);
    wait_cycles(1);
    check(req == 1'b1, "R6 next match after merged ack", req, 1);
  endtask

  task automatic t_gate();
    cfg_write(2'd3, 16'd1);
    ack_pulse();
    wait_cycles(25);
    check(req == 1'b0, "R4 interrupt enable alone no request", req, 0);
    check(flag == 1'b1, "R7 flag set with interrupt enable only", flag, 1);
    cfg_write(2'd3, 16'd2);
    ack_pulse();
    wait_cycles(25);
    check(req == 1'b0, "R4 request enable alone no request", req, 0);
    check(flag == 1'b1, "R7 flag set with request enable only", flag, 1);
    cfg_write(2'd3, 16'd3);
    ack_pulse();
  endtask

  task automatic t_buffer();
    int ok;
    ok = 0;
    for (int i = 0; i < 20 && !ok; i++) begin
      @(negedge clk);
      if (pwm) ok = 1;
    end
    ok = 0;
    for (int i = 0; i < 20 && !ok; i++) begin
      @(negedge clk);
      if (!pwm) ok = 1;
    end
    check(ok == 1, "R2 falling edge found", ok, 1);
    cmp_we = 1'b1; cmp_wdata = 16'd7;
    @(negedge clk); cmp_we = 1'b0;
    ok = 1;
    for (int i = 0; i < 5; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm) ok = 0;
    end
    check(ok == 1, "R3 staged value not used mid-period", ok, 1);
    ok = 1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (!pwm) ok = 0;
    end
    check(ok == 1, "R3 new value high for 7 cycles after reload", ok, 1);
    @(negedge clk);
    check(pwm == 1'b0, "R3 new value falls at 7", pwm, 0);
    mover_write(16'd4);
    wait_cycles(12);
  endtask

  task automatic t_zero();
    int h, r, quiet;
    mover_write(16'd0);
    wait_cycles(12);
    ack_pulse();
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm || req || flag) quiet = 0;
    end
    check(quiet == 1, "R5 zero compare no duty no match", quiet, 1);
    check(req == 1'b0, "R5 zero compare no request", req, 0);
    mover_write(16'd4);
    wait_cycles(12);
    measure(30, h, r);
    check(h == 12, "R3 update accepted after zero", h, 12);
    check(req == 1'b1, "R6 chain resumes with nonzero value", req, 1);
  endtask

  task automatic t_debug();
    int h, r, stable;
    logic lvl;
    halt = 1'b1;
    ack_pulse();
    lvl = pwm;
    stable = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm != lvl || req || flag) stable = 0;
    end
    check(stable == 1, "R8 halt freezes output and matches", stable, 1);
    cfg_write(2'd0, 16'd5);
    measure(30, h, r);
    check(h == 12, "R8 run-while-halted duty", h, 12);
    check(r == 3, "R8 run-while-halted period", r, 3);
    check(req == 1'b1, "R8 requests run while halted", req, 1);
    halt = 1'b0;
    cfg_write(2'd0, 16'd1);
  endtask

  task automatic t_init();
    int h, r;
    cfg_write(2'd1, 16'd2);
    mover_write(16'd5);
    wait_cycles(12);
    measure(24, h, r);
    check(h == 9, "R1 start value shortens high time", h, 9);
    check(r == 3, "R1 period top-start+1", r, 3);
  endtask

  task automatic t_stop();
    int low;
    cfg_write(2'd0, 16'd0);
    ack_pulse();
    low = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm || req || flag) low = 0;
    end
    check(low == 1, "R9 clock select zero stops channel", low, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period();
    t_req_merge();
    t_gate();
    t_buffer();
    t_zero();
    t_debug();
    t_init();
    t_stop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule